// File: doc/BRIEF.md
# Solenoid Driver Serial Register Interface

This block is the serial control front end of a two-channel, current-regulated solenoid driver. A host reaches it over a 4-wire SPI link. The link runs in slave mode, and each command word is 16 bits. SCK, CSB and MOSI are brought into the local clock domain through synchronizers. Each command either writes one channel's settings or asks for one read-only byte. The settings are the current level, the dither shape, the switching hysteresis, the slew rate, the fault-test source and the reference select. All of them come out on plain output ports for the analog part of the chip.

Every frame shifts back a reply to the command of the last accepted frame. For a current command, the reply carries the level exactly as the host sent it, together with three status flags for that channel:
- the fault summary;
- the out-of-range flag;
- the dither clipping flag.

A level too low to regulate is still accepted and echoed, but the effective level on the output is forced to zero. A frame may be any whole multiple of 16 clocks. Only the last 16 bits it carries act as the command. A frame of any other length is dropped. A high level on the default input returns every setting to its reset value.

Top module: `sol_spi_regs`

## Requirements
- R1: Word bits [15:14] pick the kind: 00 sets the level, 01 sets the dither, 10 sets the general config, 11 is a read. Bit 13 picks channel 0 or 1. Dither: enable = bit 12, amplitude = bits [11:7], frequency = bits [6:0]. Config: reference select = bit 12, fault-test source = bit 11, slew = bits [4:3], hysteresis = bits [2:0]. Each field appears on the output slice of its channel.
- R2: The level is bits [9:0]. A stored level of 0x029 or less drives the effective level output to 0. A stored level above 0x029 is passed through unchanged.
- R3: The reply to a level command is {word[15:13], diag, range, clip, word[9:0]}. The level in it is the value as received, never the forced zero. Replies to dither and config commands echo the whole word.
- R4: With half-hysteresis H = 17,21,25,29,33,38,42,46 counts for settings 0..7 and level L, range = (L <= 41) or (L+H > 1024) or (L < 25+H).
- R5: With half-dither D = (amplitude*21)>>2 counts, clip = (L+H+D > 1024) or (L < 25+H+D).
- R6: diag in bit 12 is the OR of that channel's open-load, short and over-temperature inputs, sampled when CSB falls.
- R7: The reply to a read is {word[15:13], 2'b00, id, byte}, with id = word[10:8]. For ids 0..4 the byte is corr_trim[(ch*5+id)*8 +: 8]. Id 5 returns REV_CODE. Ids 6 and 7 return 0x00.
- R8: A frame of 16*n clocks (n >= 1) takes its last 16 MOSI bits, MSB first, as the command. The first 16 bits on SO are the reply. SO changes after a rising SCK edge and is read at the next rising edge. SO floats while CSB is high.
- R9: A frame whose clock count is not a multiple of 16 changes no setting and does not change which command the next reply answers.
- R10: One clock after dflt goes high, all settings read as 0. While dflt is high, write frames change no setting, although the echo source still follows them.
- R11: After reset all setting outputs are 0, and the first reply answers an all-zero level command on channel 0.
- R12: Setting outputs change only at the end of a frame or on dflt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | local clock |
| rst_n | input | 1 | asynchronous active-low reset |
| csb | input | 1 | frame select, active low |
| sck | input | 1 | serial clock, idle low |
| mosi | input | 1 | serial data in |
| so | output | 1 | serial data out, floats while csb is high |
| dflt | input | 1 | active-high return to defaults |
| flt_open | input | 2 | open-load / short-to-ground fault per channel |
| flt_short | input | 2 | short-to-supply fault per channel |
| flt_hot | input | 2 | over-temperature fault per channel |
| corr_trim | input | 80 | five trim bytes per channel, channel 1 in the upper 40 bits |
| lvl_o | output | 20 | effective level, 10 bits per channel |
| dith_amp_o | output | 10 | dither amplitude, 5 bits per channel |
| dith_frq_o | output | 14 | dither frequency, 7 bits per channel |
| dith_enh_o | output | 2 | enhanced dither enable per channel |
| hyst_o | output | 6 | hysteresis setting, 3 bits per channel |
| slew_o | output | 4 | slew setting, 2 bits per channel |
| ftype_o | output | 2 | fault-test source select per channel |
| refsel_o | output | 2 | reference select per channel |

## Verification
The default input and a frame end can land on the same clock edge. When both occur, the clear must win over the write, while the echo source still takes the new word. The bench provokes this by holding dflt high across a complete level frame. It then checks that the outputs stay at 0, and that the next reply echoes the dropped level with flags computed from the cleared settings. Random frames also mix 32-bit and odd-length frames with level writes near both thresholds, so the flag arithmetic and frame rejection are judged against a bench model.

// File: rtl/sol_spi_regs.sv
module sol_spi_regs #(
  parameter logic [9:0]  LOW_CUT   = 10'd41,
  parameter logic [11:0] TOP_CNT   = 12'd1024,
  parameter logic [11:0] FLOOR_CNT = 12'd25,
  parameter logic [7:0]  REV_CODE  = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csb,
  input  logic        sck,
  input  logic        mosi,
  output logic        so,
  input  logic        dflt,
  input  logic [1:0]  flt_open,
  input  logic [1:0]  flt_short,
  input  logic [1:0]  flt_hot,
  input  logic [79:0] corr_trim,
  output logic [19:0] lvl_o,
  output logic [9:0]  dith_amp_o,
  output logic [13:0] dith_frq_o,
  output logic [1:0]  dith_enh_o,
  output logic [5:0]  hyst_o,
  output logic [3:0]  slew_o,
  output logic [1:0]  ftype_o,
  output logic [1:0]  refsel_o
);

  logic [2:0] sck_s, csb_s;
  logic [1:0] mosi_s;
  logic [15:0] sr, last, resp;
  logic [3:0] bitc;
  logic seen;

  logic [1:0][9:0] lvl;
  logic [1:0][4:0] amp;
  logic [1:0][6:0] frq;
  logic [1:0][2:0] hys;
  logic [1:0][1:0] slw;
  logic [1:0] enh, fty, rsel;

  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire cs_fall  = ~csb_s[1] & csb_s[2];
  wire cs_rise  = csb_s[1] & ~csb_s[2];
  wire active   = ~csb_s[1];
  wire good     = cs_rise & seen & (bitc == 4'd0);

  function automatic logic [11:0] half_hyst(input logic [2:0] h);
    case (h)
      3'd0: return 12'd17;
      3'd1: return 12'd21;
      3'd2: return 12'd25;
      3'd3: return 12'd29;
      3'd4: return 12'd33;
      3'd5: return 12'd38;
      3'd6: return 12'd42;
      default: return 12'd46;
    endcase
  endfunction

  logic ch;
  logic [2:0] rid;
  logic [11:0] lv, hh, dh, up;
  logic rng, clp, diag;
  logic [7:0] rdb;

  always_comb begin
    ch   = last[13];
    rid  = last[10:8];
    lv   = {2'b00, lvl[ch]};
    hh   = half_hyst(hys[ch]);
    dh   = ({7'd0, amp[ch]} * 12'd21) >> 2;
    up   = lv + hh;
    rng  = (lvl[ch] <= LOW_CUT) || (up > TOP_CNT) || (lv < FLOOR_CNT + hh);
    clp  = (up + dh > TOP_CNT) || (lv < FLOOR_CNT + hh + dh);
    diag = flt_open[ch] | flt_short[ch] | flt_hot[ch];
    rdb  = 8'h00;
    if (rid < 3'd5) rdb = corr_trim[(int'(ch) * 5 + int'(rid)) * 8 +: 8];
    else if (rid == 3'd5) rdb = REV_CODE;
    case (last[15:14])
      2'b00:   resp = {last[15:13], diag, rng, clp, last[9:0]};
      2'b11:   resp = {last[15:13], 2'b00, rid, rdb};
      default: resp = last;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0; csb_s <= '1; mosi_s <= '0;
      sr <= '0; last <= '0; bitc <= '0; seen <= 1'b0;
      lvl <= '0; amp <= '0; frq <= '0; hys <= '0; slw <= '0;
      enh <= '0; fty <= '0; rsel <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      csb_s  <= {csb_s[1:0], csb};
      mosi_s <= {mosi_s[0], mosi};
      if (cs_fall) begin
        sr <= resp; bitc <= '0; seen <= 1'b0;
      end else if (active && sck_rise) begin
        sr <= {sr[14:0], mosi_s[1]}; bitc <= bitc + 4'd1; seen <= 1'b1;
      end
      if (good) begin
        last <= sr;
        case (sr[15:14])
          2'b00: lvl[sr[13]] <= sr[9:0];
          2'b01: begin
            enh[sr[13]] <= sr[12]; amp[sr[13]] <= sr[11:7]; frq[sr[13]] <= sr[6:0];
          end
          2'b10: begin
            rsel[sr[13]] <= sr[12]; fty[sr[13]] <= sr[11];
            slw[sr[13]] <= sr[4:3]; hys[sr[13]] <= sr[2:0];
          end
          default: ;
        endcase
      end
      if (dflt) begin
        lvl <= '0; amp <= '0; frq <= '0; hys <= '0; slw <= '0;
        enh <= '0; fty <= '0; rsel <= '0;
      end
    end
  end

  assign so = csb ? 1'bz : sr[15];

  for (genvar c = 0; c < 2; c++) begin : g_out
    assign lvl_o[c*10 +: 10]     = (lvl[c] <= LOW_CUT) ? 10'd0 : lvl[c];
    assign dith_amp_o[c*5 +: 5]  = amp[c];
    assign dith_frq_o[c*7 +: 7]  = frq[c];
    assign hyst_o[c*3 +: 3]      = hys[c];
    assign slew_o[c*2 +: 2]      = slw[c];
  end
  assign dith_enh_o = enh;
  assign ftype_o    = fty;
  assign refsel_o   = rsel;

endmodule

// File: rtl/sol_spi_regs_chk.sv
module sol_spi_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csb,
  input logic        dflt,
  input logic [19:0] lvl_o,
  input logic [9:0]  dith_amp_o,
  input logic [13:0] dith_frq_o,
  input logic [1:0]  dith_enh_o,
  input logic [5:0]  hyst_o,
  input logic [3:0]  slew_o,
  input logic [1:0]  ftype_o,
  input logic [1:0]  refsel_o
);
  wire [59:0] cfg = {lvl_o, dith_amp_o, dith_frq_o, dith_enh_o, hyst_o, slew_o, ftype_o, refsel_o};

  AST_LOW_FORCED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_o[9:0] == 10'd0 || lvl_o[9:0] > 10'd41) && (lvl_o[19:10] == 10'd0 || lvl_o[19:10] > 10'd41)); // R2

  AST_DFLT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dflt |=> cfg == 60'd0); // R10

  AST_DFLT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dflt && $past(dflt)) |-> cfg == 60'd0); // R10

  AST_QUIET_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    (csb && $past(csb) && $past(csb, 2) && $past(csb, 3) && $past(csb, 4) && !$past(dflt))
      |-> $stable(cfg)); // R12
endmodule

bind sol_spi_regs sol_spi_regs_chk chk_i (.*);

// File: tb/sol_spi_regs_tb.sv
module sol_spi_regs_tb_top;
  localparam int CLK_PER = 10;

  logic clk = 1'b0, rst_n = 1'b0, csb = 1'b1, sck = 1'b0, mosi = 1'b0, dflt = 1'b0;
  logic [1:0] f_open = '0, f_short = '0, f_hot = '0;
  logic [79:0] trim;
  wire so;
  logic [19:0] lvl_o; logic [9:0] amp_o; logic [13:0] frq_o; logic [1:0] enh_o;
  logic [5:0] hyst_o; logic [3:0] slew_o; logic [1:0] fty_o, rsel_o;

  int vec = 0, bad = 0;
  logic [9:0] m_lvl[2]; logic [4:0] m_amp[2]; logic [6:0] m_frq[2];
  logic [2:0] m_hys[2]; logic [1:0] m_slw[2]; logic m_enh[2], m_fty[2], m_rsel[2];
  logic [15:0] m_last = '0;

  sol_spi_regs dut_i (.clk(clk), .rst_n(rst_n), .csb(csb), .sck(sck), .mosi(mosi), .so(so),
    .dflt(dflt), .flt_open(f_open), .flt_short(f_short), .flt_hot(f_hot), .corr_trim(trim),
    .lvl_o(lvl_o), .dith_amp_o(amp_o), .dith_frq_o(frq_o), .dith_enh_o(enh_o),
    .hyst_o(hyst_o), .slew_o(slew_o), .ftype_o(fty_o), .refsel_o(rsel_o));

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int hh(input logic [2:0] h);
    int t[8] = '{17, 21, 25, 29, 33, 38, 42, 46};
    return t[h];
  endfunction

  function automatic logic rng_f(input int l, input int h); // R4
    return (l <= 41) || (l + h > 1024) || (l < 25 + h);
  endfunction

  function automatic logic clp_f(input int l, input int h, input int d); // R5
    return (l + h + d > 1024) || (l < 25 + h + d);
  endfunction

  function automatic logic [15:0] exp_resp();
    int c = int'(m_last[13]);
    int id = int'(m_last[10:8]);
    logic [7:0] b;
    int h = hh(m_hys[c]);
    int d = (int'(m_amp[c]) * 21) / 4;
    logic dg = f_open[c] | f_short[c] | f_hot[c];
    case (m_last[15:14])
      2'b00: return {m_last[15:13], dg, rng_f(int'(m_lvl[c]), h), clp_f(int'(m_lvl[c]), h, d), m_last[9:0]};
      2'b11: begin
        b = (id < 5) ? trim[(c*5+id)*8 +: 8] : (id == 5 ? 8'h5A : 8'h00);
        return {m_last[15:13], 2'b00, m_last[10:8], b};
      end
      default: return m_last;
    endcase
  endfunction

  task automatic clear_model();
    for (int c = 0; c < 2; c++) begin
      m_lvl[c] = '0; m_amp[c] = '0; m_frq[c] = '0; m_hys[c] = '0;
      m_slw[c] = '0; m_enh[c] = 1'b0; m_fty[c] = 1'b0; m_rsel[c] = 1'b0;
    end
  endtask

  task automatic check_outputs(input string tag);
    logic [19:0] el; logic [9:0] ea; logic [13:0] ef; logic [5:0] eh; logic [3:0] es;
    for (int c = 0; c < 2; c++) begin
      el[c*10 +: 10] = (m_lvl[c] <= 10'd41) ? 10'd0 : m_lvl[c];
      ea[c*5 +: 5] = m_amp[c]; ef[c*7 +: 7] = m_frq[c];
      eh[c*3 +: 3] = m_hys[c]; es[c*2 +: 2] = m_slw[c];
    end
    chk({tag, " R2 level"}, 64'(lvl_o), 64'(el));
    chk({tag, " R1 dither"}, 64'({amp_o, frq_o, enh_o}), 64'({ea, ef, m_enh[1], m_enh[0]}));
    chk({tag, " R1 config"}, 64'({hyst_o, slew_o, fty_o, rsel_o}),
        64'({eh, es, m_fty[1], m_fty[0], m_rsel[1], m_rsel[0]}));
  endtask

  task automatic frame(input logic [15:0] w, input int nb, input string tag);
    logic [15:0] exp_r = exp_resp();
    logic [15:0] got = '0;
    int rd = (nb < 16) ? nb : 16;
    @(negedge clk); csb = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      mosi = (i >= nb - 16) ? w[15 - (i - (nb - 16))] : 1'($urandom);
      repeat (4) @(negedge clk);
      if (i < 16) got[15 - i] = so;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk); csb = 1'b1;
    repeat (8) @(negedge clk);
    if (rd == 16) chk({tag, " R3 R8 reply"}, 64'(got), 64'(exp_r));
    if (nb > 0 && nb % 16 == 0) begin
      m_last = w;
      if (!dflt) begin
        case (w[15:14])
          2'b00: m_lvl[w[13]] = w[9:0];
          2'b01: begin m_enh[w[13]] = w[12]; m_amp[w[13]] = w[11:7]; m_frq[w[13]] = w[6:0]; end
          2'b10: begin m_rsel[w[13]] = w[12]; m_fty[w[13]] = w[11]; m_slw[w[13]] = w[4:3]; m_hys[w[13]] = w[2:0]; end
          default: ;
        endcase
      end
    end
    check_outputs(tag);
  endtask

  function automatic logic [15:0] rnd_cmd();
    logic [15:0] w = 16'($urandom);
    if (w[15:14] == 2'b00) begin
      case ($urandom % 4)
        0: w[9:0] = 10'($urandom % 60);
        1: w[9:0] = 10'(1000 + $urandom % 24);
        default: ;
      endcase
    end
    return w;
  endfunction

  initial begin
    #(CLK_PER * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    trim = {16'($urandom), 32'($urandom), 32'($urandom)};
    clear_model();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_outputs("R11 reset");
    frame(16'h0029, 16, "R11 first reply");
    frame(16'h002A, 16, "R2 low cut 0x029");
    frame(16'h202A, 16, "R2 above cut");
    frame(16'h8007, 16, "R4 hyst max");
    frame(16'h7FFF, 16, "R5 dither max");
    frame(16'h03FF, 16, "R1 dither reply");
    f_hot = 2'b10; f_open = 2'b01;
    frame(16'h2100, 16, "R6 diag");
    frame(16'h0000, 16, "R6 diag ch1");
    f_hot = '0; f_open = '0;
    for (int c = 0; c < 2; c++)
      for (int id = 0; id < 8; id++)
        frame({2'b11, 1'(c), 2'b00, 3'(id), 8'h00}, 16, "R7 read");
    frame(16'hC000, 16, "R7 last read");
    frame(16'h0155, 32, "R8 two words");
    frame(16'h0222, 17, "R9 odd count");
    frame(16'h0333, 15, "R9 short");
    frame(16'h0000, 16, "R9 echo kept");
    @(negedge clk); dflt = 1'b1; clear_model();
    @(negedge clk); @(negedge clk);
    check_outputs("R10 dflt pulse");
    frame(16'h0300, 16, "R10 write under dflt");
    @(negedge clk); dflt = 1'b0;
    frame(16'h0000, 16, "R10 echo after dflt");
    for (int n = 0; n < 150; n++) begin
      int sel = $urandom % 8;
      int nb = (sel == 0) ? 32 : (sel == 1 ? 1 + ($urandom % 47) : 16);
      @(negedge clk);
      f_open = 2'($urandom); f_short = 2'($urandom); f_hot = 2'($urandom);
      frame(rnd_cmd(), nb, "R1 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule